// File: doc/BRIEF.md
# Bridge Secondary Reset Sequencer

This block sequences the reset of the secondary bus behind a PCI-to-PCI bridge. Four things can start a reset: the active-low primary reset, the active-low secondary reset input, a one-cycle software write that sets a chip-reset bit, and a one-cycle request raised when the device is woken from D3hot to D0. While any reset is in force, the secondary reset output is held low and the quiesce output tells the rest of the bridge to float every PCI output.

During a reset, the block reads strap line 6 of the primary address/data bus. If that line is low, the bridge is the central function of the secondary bus. It then enables the drivers of the secondary address/data, byte-enable and parity pins so that they drive zero. When the bridge is built with a 64-bit secondary side, it also drives the 64-bit request pin. If strap line 6 is high, another agent is the central function and every secondary pin is left floating.

A hardware reset ends when its input is released. Release passes through a two-stage synchronizer, while assertion takes effect at once. An internal reset (chip-reset bit or wake request) ends after a parameterised number of clock cycles. On the first cycle after any reset ends, straps 3, 4, 5 and 7 are captured as configuration bits. They then stay fixed until the next capture. The chip-reset bit clears itself at that same point.

Top module: `bridge_sec_reset_seq`

## Requirements
- R1: A low level on `prim_rst_n` or `sec_rst_in_n` drives `sec_rst_n` low and `pci_quiesce` high at once, without a clock edge, and clears `chip_rst_bit`.
- R2: After the last hardware reset input is released between two clock edges, `sec_rst_n` stays low through the second following rising edge and goes high after the third.
- R3: During reset with strap line 6 (`ad_strap[6]`) low, `central_fn`, `sec_ad_oe`, `sec_cbe_oe` and `sec_par_oe` are 1 (pins driven to zero), while `sec_ctl_oe` and `sec_ext64_oe` are 0.
- R4: With `SEC_64BIT`=1, `sec_req64_oe` is 1 exactly when the bridge is central function and reset is in force; it is never 1 otherwise.
- R5: During reset with `ad_strap[6]` high, every secondary output enable and `central_fn` are 0.
- R6: Outside reset, `pci_quiesce`, `central_fn` and every secondary output enable are 0.
- R7: On the rising edge after `sec_rst_n` goes high, the configuration outputs are captured: `cfg_lockout` = `ad_strap[3]`, `cfg_sync_mode` = NOT `ad_strap[4]`, `cfg_sclk_en` = `ad_strap[5]`, `cfg_arb_en` = `ad_strap[7]`. After a hardware reset, before any capture, the values are 0, 0, 1, 1.
- R8: Outside reset, changes on `ad_strap` leave the four configuration outputs unchanged.
- R9: A `chip_rst_wr` pulse while idle sets `chip_rst_bit` on that edge and holds `sec_rst_n` low for exactly `HOLD_CYCLES` cycles. `chip_rst_bit` clears on the edge after `sec_rst_n` rises, which is the same edge that captures the straps.
- R10: A `pm_d0_wake` pulse while idle holds `sec_rst_n` low for exactly `HOLD_CYCLES` cycles and leaves `chip_rst_bit` at 0.
- R11: A hardware reset that arrives during an internal hold ends by the R2 rule only. The cycle counter has no effect, however long the hardware reset lasts.
- R12: A `chip_rst_wr` pulse on the capture edge still captures the straps, leaves `chip_rst_bit` set, and starts a new hold of `HOLD_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| prim_rst_n | input | 1 | Primary reset, active low, asynchronous |
| sec_rst_in_n | input | 1 | Secondary reset input, active low, asynchronous |
| chip_rst_wr | input | 1 | One-cycle write setting the chip-reset bit |
| pm_d0_wake | input | 1 | One-cycle D3hot-to-D0 reset request |
| ad_strap | input | 5 | Primary address/data strap lines 7..3 |
| sec_rst_n | output | 1 | Secondary bus reset, active low |
| pci_quiesce | output | 1 | Float all PCI outputs while high |
| sec_ad_oe | output | 1 | Drive secondary address/data low |
| sec_cbe_oe | output | 1 | Drive secondary byte enables low |
| sec_par_oe | output | 1 | Drive secondary parity low |
| sec_ctl_oe | output | 1 | Secondary control pin enable |
| sec_req64_oe | output | 1 | Drive 64-bit request (asserted) |
| sec_ext64_oe | output | 1 | Other 64-bit extension pin enable |
| chip_rst_bit | output | 1 | Chip-reset bit, self-clearing |
| central_fn | output | 1 | Bridge is secondary central function |
| cfg_lockout | output | 1 | Captured primary lockout reset value |
| cfg_sync_mode | output | 1 | Captured synchronous-mode select |
| cfg_sclk_en | output | 1 | Secondary clock output enable |
| cfg_arb_en | output | 1 | Internal arbiter enable |

## Verification
The capture cycle and a new internal reset request can land on the same edge. The bench provokes this by releasing a hardware reset, counting three edges, and then raising `chip_rst_wr` for exactly the edge on which the straps are captured. The check passes when the new strap pattern is captured, `chip_rst_bit` stays at 1 instead of self-clearing, and the secondary reset returns low for a full hold. A second overlap puts a hardware reset on top of a running internal hold. The bench holds it well past the hold count and then checks that release follows the synchronizer timing.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_LATCH = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic lockout;
      logic sync_mode;
      logic sclk_en;
      logic arb_en;
   } strap_cfg_t;

   // strap line positions on the primary address/data bus
   localparam int STRAP_LOCKOUT = 3;
   localparam int STRAP_SYNC_N  = 4;
   localparam int STRAP_SCLK    = 5;
   localparam int STRAP_CENTRAL = 6;
   localparam int STRAP_ARB     = 7;

   localparam strap_cfg_t CFG_AFTER_HW = '{lockout: 1'b0, sync_mode: 1'b0,
                                           sclk_en: 1'b1, arb_en: 1'b1};

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bsr_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '1;
      else      chain <= {chain[STAGES-2:0], 1'b0};
   end

   assign rst_q = chain[STAGES-1];

endmodule

// File: rtl/bsr_hold_timer.sv
module bsr_hold_timer #(
   parameter int HOLD_CYCLES = 3300
) (
   input  logic clk,
   input  logic arst,
   input  logic clear,
   input  logic run,
   output logic done
);

   localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("bsr_hold_timer: HOLD_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)                   cnt <= '0;
      else if (clear)             cnt <= '0;
      else if (run && cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LAST);

endmodule

// File: rtl/bsr_pin_ctrl.sv
module bsr_pin_ctrl #(
   parameter bit SEC_64BIT = 1'b1
) (
   input  logic in_rst,
   input  logic strap_central_n,
   output logic central,
   output logic ad_oe,
   output logic cbe_oe,
   output logic par_oe,
   output logic ctl_oe,
   output logic req64_oe,
   output logic ext64_oe
);

   assign central  = in_rst & ~strap_central_n;
   assign ad_oe    = central;
   assign cbe_oe   = central;
   assign par_oe   = central;
   assign ctl_oe   = 1'b0;
   assign ext64_oe = 1'b0;

   if (SEC_64BIT) begin : g_wide
      assign req64_oe = central;
   end else begin : g_narrow
      assign req64_oe = 1'b0;
   end

endmodule

// File: rtl/bridge_sec_reset_seq.sv
module bridge_sec_reset_seq
   import bsr_pkg::*;
#(
   parameter int HOLD_CYCLES = 3300,
   parameter int SYNC_STAGES = 2,
   parameter bit SEC_64BIT   = 1'b1
) (
   input  logic       clk,
   input  logic       prim_rst_n,
   input  logic       sec_rst_in_n,
   input  logic       chip_rst_wr,
   input  logic       pm_d0_wake,
   input  logic [7:3] ad_strap,
   output logic       sec_rst_n,
   output logic       pci_quiesce,
   output logic       sec_ad_oe,
   output logic       sec_cbe_oe,
   output logic       sec_par_oe,
   output logic       sec_ctl_oe,
   output logic       sec_req64_oe,
   output logic       sec_ext64_oe,
   output logic       chip_rst_bit,
   output logic       central_fn,
   output logic       cfg_lockout,
   output logic       cfg_sync_mode,
   output logic       cfg_sclk_en,
   output logic       cfg_arb_en
);

   logic       hw_arst;
   logic       hw_hold;
   logic       soft_req;
   logic       int_rst;
   logic       hold_done;
   logic       in_rst;
   seq_state_e state;
   strap_cfg_t cfg_q;

   assign hw_arst  = ~prim_rst_n | ~sec_rst_in_n;
   assign soft_req = chip_rst_wr | pm_d0_wake;

   bsr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .arst  (hw_arst),
      .rst_q (hw_hold)
   );

   bsr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk   (clk),
      .arst  (hw_arst),
      .clear (state != ST_HOLD),
      .run   (state == ST_HOLD && int_rst && !hw_hold),
      .done  (hold_done)
   );

   // sequence: hold reset, then one capture cycle, then idle
   always_ff @(posedge clk or posedge hw_arst) begin
      if (hw_arst) begin
         state   <= ST_HOLD;
         int_rst <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (soft_req) begin
                  state   <= ST_HOLD;
                  int_rst <= 1'b1;
               end
            end
            ST_HOLD: begin
               if (hw_hold) begin
                  int_rst <= 1'b0;
               end else if (!int_rst || hold_done) begin
                  state   <= ST_LATCH;
                  int_rst <= 1'b0;
               end
            end
            ST_LATCH: begin
               if (soft_req) begin
                  state   <= ST_HOLD;
                  int_rst <= 1'b1;
               end else begin
                  state   <= ST_IDLE;
               end
            end
            default: begin
               state   <= ST_HOLD;
               int_rst <= 1'b0;
            end
         endcase
      end
   end

   // chip-reset bit: a write wins over self-clear in the capture cycle
   always_ff @(posedge clk or posedge hw_arst) begin
      if (hw_arst)               chip_rst_bit <= 1'b0;
      else if (chip_rst_wr)      chip_rst_bit <= 1'b1;
      else if (state == ST_LATCH) chip_rst_bit <= 1'b0;
   end

   always_ff @(posedge clk or posedge hw_arst) begin
      if (hw_arst) begin
         cfg_q <= CFG_AFTER_HW;
      end else if (state == ST_LATCH) begin
         cfg_q.lockout   <= ad_strap[STRAP_LOCKOUT];
         cfg_q.sync_mode <= ~ad_strap[STRAP_SYNC_N];
         cfg_q.sclk_en   <= ad_strap[STRAP_SCLK];
         cfg_q.arb_en    <= ad_strap[STRAP_ARB];
      end
   end

   assign in_rst      = hw_arst | (state == ST_HOLD);
   assign sec_rst_n   = ~in_rst;
   assign pci_quiesce = in_rst;

   bsr_pin_ctrl #(.SEC_64BIT(SEC_64BIT)) u_pins (
      .in_rst          (in_rst),
      .strap_central_n (ad_strap[STRAP_CENTRAL]),
      .central         (central_fn),
      .ad_oe           (sec_ad_oe),
      .cbe_oe          (sec_cbe_oe),
      .par_oe          (sec_par_oe),
      .ctl_oe          (sec_ctl_oe),
      .req64_oe        (sec_req64_oe),
      .ext64_oe        (sec_ext64_oe)
   );

   assign cfg_lockout   = cfg_q.lockout;
   assign cfg_sync_mode = cfg_q.sync_mode;
   assign cfg_sclk_en   = cfg_q.sclk_en;
   assign cfg_arb_en    = cfg_q.arb_en;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker (
   input logic clk,
   input logic prim_rst_n,
   input logic sec_rst_in_n,
   input logic sec_rst_n,
   input logic sec_ad_oe,
   input logic sec_cbe_oe,
   input logic sec_par_oe,
   input logic sec_req64_oe,
   input logic chip_rst_bit,
   input logic cfg_lockout,
   input logic cfg_sync_mode,
   input logic cfg_sclk_en,
   input logic cfg_arb_en
);

   logic       hw_any;
   logic [3:0] cfg_v;

   assign hw_any = !prim_rst_n || !sec_rst_in_n;
   assign cfg_v  = {cfg_lockout, cfg_sync_mode, cfg_sclk_en, cfg_arb_en};

   always_comb begin
      if (hw_any) assert_hw_forces_rst_R1: assert (!sec_rst_n);
   end

   assert_idle_pins_float_R6: assert property (@(posedge clk) disable iff (hw_any)
      sec_rst_n |-> !(sec_ad_oe || sec_cbe_oe || sec_par_oe || sec_req64_oe));

   assert_req64_only_central_R4: assert property (@(posedge clk) disable iff (hw_any)
      sec_req64_oe |-> (!sec_rst_n && sec_ad_oe));

   assert_cfg_stable_R8: assert property (@(posedge clk) disable iff (hw_any)
      (sec_rst_n && $past(sec_rst_n) && $past(sec_rst_n, 2)) |-> $stable(cfg_v));

   assert_bit_clears_after_rst_R9: assert property (@(posedge clk) disable iff (hw_any)
      $fell(chip_rst_bit) |-> sec_rst_n);

endmodule

bind bridge_sec_reset_seq bsr_checker u_chk (
   .clk          (clk),
   .prim_rst_n   (prim_rst_n),
   .sec_rst_in_n (sec_rst_in_n),
   .sec_rst_n    (sec_rst_n),
   .sec_ad_oe    (sec_ad_oe),
   .sec_cbe_oe   (sec_cbe_oe),
   .sec_par_oe   (sec_par_oe),
   .sec_req64_oe (sec_req64_oe),
   .chip_rst_bit (chip_rst_bit),
   .cfg_lockout  (cfg_lockout),
   .cfg_sync_mode(cfg_sync_mode),
   .cfg_sclk_en  (cfg_sclk_en),
   .cfg_arb_en   (cfg_arb_en)
);

// File: tb/bridge_sec_reset_seq_tb.sv
module bridge_sec_reset_seq_tb;

   localparam int HOLD = 12;

   logic       clk = 1'b0;
   logic       prim_rst_n, sec_rst_in_n, chip_rst_wr, pm_d0_wake;
   logic [7:3] ad_strap;
   logic       sec_rst_n, pci_quiesce, sec_ad_oe, sec_cbe_oe, sec_par_oe;
   logic       sec_ctl_oe, sec_req64_oe, sec_ext64_oe, chip_rst_bit, central_fn;
   logic       cfg_lockout, cfg_sync_mode, cfg_sclk_en, cfg_arb_en;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   bridge_sec_reset_seq #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2), .SEC_64BIT(1'b1)) u_dut (
      .clk(clk), .prim_rst_n(prim_rst_n), .sec_rst_in_n(sec_rst_in_n),
      .chip_rst_wr(chip_rst_wr), .pm_d0_wake(pm_d0_wake), .ad_strap(ad_strap),
      .sec_rst_n(sec_rst_n), .pci_quiesce(pci_quiesce), .sec_ad_oe(sec_ad_oe),
      .sec_cbe_oe(sec_cbe_oe), .sec_par_oe(sec_par_oe), .sec_ctl_oe(sec_ctl_oe),
      .sec_req64_oe(sec_req64_oe), .sec_ext64_oe(sec_ext64_oe),
      .chip_rst_bit(chip_rst_bit), .central_fn(central_fn),
      .cfg_lockout(cfg_lockout), .cfg_sync_mode(cfg_sync_mode),
      .cfg_sclk_en(cfg_sclk_en), .cfg_arb_en(cfg_arb_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   function automatic logic [3:0] exp_cfg(input logic [7:3] s);
      return {s[3], ~s[4], s[5], s[7]};
   endfunction

   function automatic logic [3:0] cfg_now();
      return {cfg_lockout, cfg_sync_mode, cfg_sclk_en, cfg_arb_en};
   endfunction

   function automatic logic [6:0] pins_now();
      return {central_fn, sec_ad_oe, sec_cbe_oe, sec_par_oe, sec_ctl_oe, sec_req64_oe, sec_ext64_oe};
   endfunction

   // counts low cycles of sec_rst_n, starting just after the entry edge
   task automatic count_hold(output int n);
      n = 0;
      while (!sec_rst_n && n < 100) begin
         tick();
         n++;
      end
   endtask

   task automatic t_reset_state();
      #3;
      chk("R1 reset low at time zero", {30'd0, sec_rst_n, pci_quiesce}, 32'h1);
      tick();
      chk("R7 post-hw cfg defaults", cfg_now(), 4'b0011);
      chk("R1 chip bit cleared", chip_rst_bit, 0);
   endtask

   task automatic t_central_release();
      ad_strap = 5'b0_0_1_0_1; // [7]=0 [6]=0 [5]=1 [4]=0 [3]=1
      #1;
      chk("R3 central pins driven", pins_now(), 7'b1111010);
      chk("R4 req64 driven when central", sec_req64_oe, 1);
      prim_rst_n = 1'b1;
      tick();
      tick();
      chk("R2 still low after 2 edges", sec_rst_n, 0);
      tick();
      chk("R2 high after 3rd edge", sec_rst_n, 1);
      chk("R6 pins float outside reset", {pins_now(), pci_quiesce}, 0);
      ad_strap = 5'b1_1_0_1_0;
      tick();
      chk("R7 capture on edge after release", cfg_now(), exp_cfg(5'b1_1_0_1_0));
   endtask

   task automatic t_async_noncentral();
      ad_strap = 5'b1_1_1_1_1;
      #3;
      sec_rst_in_n = 1'b0;
      #1;
      chk("R1 async assert without edge", {30'd0, sec_rst_n, pci_quiesce}, 32'h1);
      chk("R5 non-central pins float", pins_now(), 0);
      tick();
      chk("R5 non-central req64 off", sec_req64_oe, 0);
      chk("R7 cfg back to defaults", cfg_now(), 4'b0011);
      sec_rst_in_n = 1'b1;
      ad_strap = 5'b0_1_0_0_1;
      repeat (4) tick();
      chk("R7 second pattern captured", cfg_now(), exp_cfg(5'b0_1_0_0_1));
   endtask

   task automatic t_idle_stable();
      logic [3:0] held;
      held = cfg_now();
      for (int i = 0; i < 8; i++) begin
         ad_strap = 5'(i * 7 + 3);
         tick();
      end
      chk("R8 cfg unchanged by idle strap moves", cfg_now(), held);
      ad_strap = 5'b0_0_0_0_0;
      tick();
      chk("R6 idle pins float with strap6 low", {pins_now(), pci_quiesce}, 0);
   endtask

   task automatic t_chip_reset();
      int n;
      ad_strap = 5'b1_0_1_1_0;
      chip_rst_wr = 1'b1;
      tick();
      chip_rst_wr = 1'b0;
      chk("R9 bit set on write edge", chip_rst_bit, 1);
      chk("R3 internal reset central pins", pins_now(), 7'b1111010);
      ad_strap = 5'b0_1_1_0_0;
      count_hold(n);
      chk("R9 hold length", n, HOLD);
      chk("R9 bit held during capture cycle", chip_rst_bit, 1);
      tick();
      chk("R9 bit self-clears", chip_rst_bit, 0);
      chk("R9 straps captured after internal reset", cfg_now(), exp_cfg(5'b0_1_1_0_0));
   endtask

   task automatic t_pm_wake();
      int n;
      pm_d0_wake = 1'b1;
      tick();
      pm_d0_wake = 1'b0;
      chk("R10 reset entered on wake", sec_rst_n, 0);
      count_hold(n);
      chk("R10 hold length", n, HOLD);
      chk("R10 bit untouched", chip_rst_bit, 0);
   endtask

   task automatic t_hw_over_hold();
      chip_rst_wr = 1'b1;
      tick();
      chip_rst_wr = 1'b0;
      repeat (3) tick();
      prim_rst_n = 1'b0;
      #1;
      chk("R11 hw clears bit mid hold", chip_rst_bit, 0);
      repeat (HOLD + 6) tick();
      chk("R11 counter ignored under hw", sec_rst_n, 0);
      prim_rst_n = 1'b1;
      tick();
      tick();
      chk("R11 low through 2nd edge", sec_rst_n, 0);
      tick();
      chk("R11 release by sync rule", sec_rst_n, 1);
      tick();
   endtask

   task automatic t_collision();
      int n;
      sec_rst_in_n = 1'b0;
      repeat (2) tick();
      sec_rst_in_n = 1'b1;
      tick();
      tick();
      tick();
      chk("R12 capture cycle reached", sec_rst_n, 1);
      ad_strap = 5'b1_0_0_0_1;
      chip_rst_wr = 1'b1;
      tick();
      chip_rst_wr = 1'b0;
      chk("R12 straps captured", cfg_now(), exp_cfg(5'b1_0_0_0_1));
      chk("R12 bit kept set", chip_rst_bit, 1);
      chk("R12 new hold started", sec_rst_n, 0);
      count_hold(n);
      chk("R12 new hold length", n, HOLD);
      tick();
      chk("R12 bit clears after new hold", chip_rst_bit, 0);
   endtask

   initial begin
      prim_rst_n   = 1'b0;
      sec_rst_in_n = 1'b1;
      chip_rst_wr  = 1'b0;
      pm_d0_wake   = 1'b0;
      ad_strap     = 5'b1_1_1_1_1;
      t_reset_state();
      t_central_release();
      t_async_noncentral();
      t_idle_stable();
      t_chip_reset();
      t_pm_wake();
      t_hw_over_hold();
      t_collision();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule